// File: doc/BRIEF.md
# Multi-cycle 24-bit accumulator processor core

This core is a small processor with a 24-bit accumulator. It executes one instruction at a time from a byte-wide synchronous memory that has a 15-bit address. Its 24-bit words are built from three bytes, fetched or written one per cycle. The core holds:

- an accumulator;
- an index register;
- a link register, which takes the return address of a subroutine call;
- a program counter;
- a status word that carries a two-bit condition code.

The core covers the following instructions:

- loads and stores of the accumulator and of the index register;
- two's-complement add and subtract;
- signed compare;
- an unconditional jump, and three jumps that depend on the condition code;
- subroutine call and return;
- three device operations: test a device, read one byte from it, and write one byte to it.

Device transfers move only the low byte of the accumulator. They use a simple handshake with an 8-bit device code. Any opcode outside the supported set stops the core and raises a halt flag.

The core is meant for a small control subsystem. The integrator places program and data in the attached memory, releases reset, and execution starts at address 0.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, index, link and condition code. The first cycle after reset issues a memory read of address 0, and `halt` is low.
- R2: An instruction is one word with three fields:
  - bits 23:16 hold the opcode;
  - bit 15 is the index flag;
  - bits 14:0 hold the address field.
  
  A word is three bytes at consecutive addresses. The byte at the lowest address is bits 23:16.
- R3: Memory reads have one cycle of latency: the data for a read issued in cycle n is on `mem_rdata` in cycle n+1. Timing, counted in cycles:

  | Step | Cycles | Bus activity |
  |---|---|---|
  | Instruction fetch | 4 | reads of PC, PC+1 and PC+2, then one idle cycle |
  | Decode | 1 | idle |
  | Operand read | 4 | same pattern as the fetch |
  | Execute | 1 | — |
  | Store | 3 | writes |

  `mem_rd` and `mem_wr` are never high together.
- R4: The target address is formed as follows, with the sum taken modulo 2^15:
  - with the index flag at 0, it is the address field;
  - with the index flag at 1, it is the address field plus X[14:0].
- R5: Loads and stores:
  - Load A (0x00) and load X (0x04) copy the word at the target address.
  - Store A (0x0C) and store X (0x10) write the register to target, target+1 and target+2, highest byte first.
- R6: Add (0x18) and subtract (0x1C) combine A with the memory word and leave the result in A. The result is truncated to 24 bits, with no trap.
- R7: Compare (0x28) sets the condition code from a signed comparison of A with the memory word. The codes are 00 for equal, 01 for A less, and 10 for A greater. The jumps load PC with the target address:
  - jump-if-equal (0x30) when the code is 00;
  - jump-if-greater (0x34) when the code is 10;
  - jump-if-less (0x38) when the code is 01;
  - jump (0x3C) always.
- R8: Call (0x48) writes the address of the next instruction into the link register and jumps to the target. Return (0x4C) loads PC from the link register.
- R9: Device operations take the device code from the byte at the target address. Test device (0xE0) drives that code on `dev_code` in its execute cycle. It then sets the condition code to 01 if `dev_ready` is high, and to 00 otherwise.
- R10: Read device (0xD8) holds `dev_rd` and `dev_code` until `dev_ready`. In that cycle it copies `dev_rdata` into A[7:0]. A[23:8] is unchanged.
- R11: Write device (0xDC) holds `dev_wr` and `dev_code`, with `dev_wdata` equal to A[7:0], until `dev_ready` is high.
- R12: Any other opcode raises `halt` in the cycle after decode. `halt` then stays high, and no further memory access takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 15 | Byte address for the current memory cycle |
| mem_rd | output | 1 | Read request; data returns in the next cycle |
| mem_wr | output | 1 | Write strobe for `mem_wdata` |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned by the read of the previous cycle |
| dev_code | output | 8 | Code of the addressed device, zero when idle |
| dev_rd | output | 1 | Request for a byte from the device |
| dev_wr | output | 1 | Offer of a byte to the device |
| dev_wdata | output | 8 | Byte offered to the device (A[7:0]) |
| dev_rdata | input | 8 | Byte from the device |
| dev_ready | input | 1 | Device ready / transfer accepted |
| halt | output | 1 | Undefined opcode seen; core stopped |

## Verification
A call does two things in one decode cycle: it captures the link register and it redirects the program counter. The link must therefore hold the already-advanced PC, not the redirected one. The bench provokes this with a call into a subroutine that performs a device read and then returns. The check is the fetch address that follows the return, compared cycle by cycle against a behavioural model.

A device test also does two things in one cycle: it samples `dev_ready` and writes the condition code. Device codes whose readiness differs drive this case. A conditional jump placed just after each test, with a halting opcode on its fall-through path, makes any wrong code visible on the bus.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int WORD_W     = 24;
  localparam int BYTE_W     = 8;
  localparam int OPC_W      = 8;
  localparam int ADDR_W     = WORD_W - OPC_W - 1;
  localparam int XBIT       = ADDR_W;
  localparam int WORD_BYTES = WORD_W / BYTE_W;
  localparam int CNT_W      = $clog2(WORD_BYTES + 1);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OPC_W-1:0]  opc_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [1:0]        cc_t;

  localparam cc_t CC_EQ = 2'b00;
  localparam cc_t CC_LT = 2'b01;
  localparam cc_t CC_GT = 2'b10;

  localparam opc_t OP_LDA  = 8'h00;
  localparam opc_t OP_LDX  = 8'h04;
  localparam opc_t OP_STA  = 8'h0C;
  localparam opc_t OP_STX  = 8'h10;
  localparam opc_t OP_ADD  = 8'h18;
  localparam opc_t OP_SUB  = 8'h1C;
  localparam opc_t OP_COMP = 8'h28;
  localparam opc_t OP_JEQ  = 8'h30;
  localparam opc_t OP_JGT  = 8'h34;
  localparam opc_t OP_JLT  = 8'h38;
  localparam opc_t OP_J    = 8'h3C;
  localparam opc_t OP_JSUB = 8'h48;
  localparam opc_t OP_RSUB = 8'h4C;
  localparam opc_t OP_RD   = 8'hD8;
  localparam opc_t OP_WD   = 8'hDC;
  localparam opc_t OP_TD   = 8'hE0;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_OPRD, ST_EXEC, ST_STORE, ST_DEV, ST_HALT
  } state_e;

  function automatic word_t add_word(word_t a, word_t b);
    return a + b;
  endfunction

  function automatic word_t sub_word(word_t a, word_t b);
    return a - b;
  endfunction

  function automatic cc_t compare_cc(word_t a, word_t b);
    if ($signed(a) < $signed(b)) return CC_LT;
    if (a == b) return CC_EQ;
    return CC_GT;
  endfunction

  function automatic addr_t target_addr(addr_t field, logic xflag, word_t xr);
    return xflag ? addr_t'(field + xr[ADDR_W-1:0]) : field;
  endfunction

  function automatic byte_t word_byte(word_t w, logic [CNT_W-1:0] idx);
    return w[WORD_W-1 - int'(idx)*BYTE_W -: BYTE_W];
  endfunction

  function automatic logic opcode_known(opc_t op);
    case (op)
      OP_LDA, OP_LDX, OP_STA, OP_STX, OP_ADD, OP_SUB, OP_COMP,
      OP_JEQ, OP_JGT, OP_JLT, OP_J, OP_JSUB, OP_RSUB,
      OP_RD, OP_WD, OP_TD: return 1'b1;
      default:             return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu import acc_cpu_pkg::*; (
  input  opc_t  op,
  input  word_t a,
  input  word_t b,
  output word_t result,
  output cc_t   cc
);
  always_comb begin
    result = (op == OP_SUB) ? sub_word(a, b) : add_word(a, b);
    cc     = compare_cc(a, b);
  end
endmodule

// File: rtl/acc_cpu_bus.sv
module acc_cpu_bus import acc_cpu_pkg::*; (
  input  state_e           state,
  input  logic [CNT_W-1:0] cnt,
  input  addr_t            pc,
  input  addr_t            ta,
  input  word_t            store_word,
  output addr_t            mem_addr,
  output logic             mem_rd,
  output logic             mem_wr,
  output byte_t            mem_wdata
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_BYTES);

  addr_t base;
  always_comb begin
    base      = (state == ST_FETCH) ? pc : ta;
    mem_addr  = base + addr_t'(cnt);
    mem_rd    = ((state == ST_FETCH) || (state == ST_OPRD)) && (cnt < LAST);
    mem_wr    = (state == ST_STORE);
    mem_wdata = word_byte(store_word, cnt);
  end
endmodule

// File: rtl/acc_cpu_wasm.sv
module acc_cpu_wasm import acc_cpu_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  capture,
  input  byte_t byte_in,
  output word_t word_now
);
  localparam int HELD_W = WORD_W - BYTE_W;

  logic [HELD_W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (capture) held <= {held[HELD_W-BYTE_W-1:0], byte_in};
  end

  assign word_now = {held, byte_in};
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu import acc_cpu_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  output logic [14:0]       mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic [7:0]        dev_code,
  output logic              dev_rd,
  output logic              dev_wr,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata,
  input  logic              dev_ready,
  output logic              halt
);
  localparam logic [CNT_W-1:0] LAST       = CNT_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0] STORE_LAST = CNT_W'(WORD_BYTES - 1);
  localparam addr_t            STEP       = addr_t'(WORD_BYTES);

  state_e           state;
  logic [CNT_W-1:0] cnt;
  addr_t            pc, link, ta;
  word_t            acc, xr, ir, opnd;
  cc_t              cc;

  // decoded fields and named events
  opc_t  op;
  addr_t field, tgt;
  word_t word_now, alu_res;
  cc_t   alu_cc;
  logic  xflag, capture, xfer_last, fetch_done, operand_done;
  logic  illegal, jmp_taken, is_jump, is_store, is_dev_op;
  logic  dev_phase, dev_done, store_last;

  assign op           = ir[WORD_W-1 -: OPC_W];
  assign xflag        = ir[XBIT];
  assign field        = ir[ADDR_W-1:0];
  assign tgt          = target_addr(field, xflag, xr);
  assign xfer_last    = (cnt == LAST);
  assign capture      = ((state == ST_FETCH) || (state == ST_OPRD)) && (cnt != '0);
  assign fetch_done   = (state == ST_FETCH) && xfer_last;
  assign operand_done = (state == ST_OPRD) && xfer_last;
  assign illegal      = (state == ST_DECODE) && !opcode_known(op);
  assign is_store     = (op == OP_STA) || (op == OP_STX);
  assign is_dev_op    = (op == OP_TD) || (op == OP_RD) || (op == OP_WD);
  assign dev_phase    = ((state == ST_EXEC) && is_dev_op) || (state == ST_DEV);
  assign dev_done     = (state == ST_DEV) && dev_ready;
  assign store_last   = (state == ST_STORE) && (cnt == STORE_LAST);

  always_comb begin
    is_jump   = 1'b1;
    jmp_taken = 1'b0;
    case (op)
      OP_J:    jmp_taken = 1'b1;
      OP_JEQ:  jmp_taken = (cc == CC_EQ);
      OP_JLT:  jmp_taken = (cc == CC_LT);
      OP_JGT:  jmp_taken = (cc == CC_GT);
      default: is_jump   = 1'b0;
    endcase
  end

  acc_cpu_wasm u_wasm (
    .clk(clk), .rst(rst), .capture(capture), .byte_in(mem_rdata), .word_now(word_now)
  );

  acc_cpu_alu u_alu (
    .op(op), .a(acc), .b(opnd), .result(alu_res), .cc(alu_cc)
  );

  acc_cpu_bus u_bus (
    .state(state), .cnt(cnt), .pc(pc), .ta(ta), .store_word(opnd),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FETCH;
      cnt   <= '0;
      pc    <= '0;
      link  <= '0;
      ta    <= '0;
      acc   <= '0;
      xr    <= '0;
      ir    <= '0;
      opnd  <= '0;
      cc    <= CC_EQ;
    end else begin
      case (state)
        ST_FETCH: begin
          if (fetch_done) begin
            ir    <= word_now;
            pc    <= pc + STEP;
            cnt   <= '0;
            state <= ST_DECODE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DECODE: begin
          ta  <= tgt;
          cnt <= '0;
          if (illegal) begin
            state <= ST_HALT;
          end else if (is_jump) begin
            if (jmp_taken) pc <= tgt;
            state <= ST_FETCH;
          end else if (op == OP_JSUB) begin
            link  <= pc;
            pc    <= tgt;
            state <= ST_FETCH;
          end else if (op == OP_RSUB) begin
            pc    <= link;
            state <= ST_FETCH;
          end else if (is_store) begin
            opnd  <= (op == OP_STX) ? xr : acc;
            state <= ST_STORE;
          end else begin
            state <= ST_OPRD;
          end
        end
        ST_OPRD: begin
          if (operand_done) begin
            opnd  <= word_now;
            cnt   <= '0;
            state <= ST_EXEC;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_EXEC: begin
          state <= ST_FETCH;
          case (op)
            OP_LDA:         acc <= opnd;
            OP_LDX:         xr  <= opnd;
            OP_ADD, OP_SUB: acc <= alu_res;
            OP_COMP:        cc  <= alu_cc;
            OP_TD:          cc  <= dev_ready ? CC_LT : CC_EQ;
            OP_RD, OP_WD:   state <= ST_DEV;
            default:        ;
          endcase
        end
        ST_DEV: begin
          if (dev_done) begin
            if (op == OP_RD) acc[BYTE_W-1:0] <= dev_rdata;
            state <= ST_FETCH;
          end
        end
        ST_STORE: begin
          if (store_last) begin
            cnt   <= '0;
            state <= ST_FETCH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dev_code  = dev_phase ? opnd[WORD_W-1 -: BYTE_W] : '0;
  assign dev_rd    = (state == ST_DEV) && (op == OP_RD);
  assign dev_wr    = (state == ST_DEV) && (op == OP_WD);
  assign dev_wdata = acc[BYTE_W-1:0];
  assign halt      = (state == ST_HALT);

  // assertions next to the logic they guard
  assert_bus_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_rd_seq_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd) && !$past(rst)) |-> (mem_addr == addr_t'($past(mem_addr) + 1'b1)));

  assert_wr_seq_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == addr_t'($past(mem_addr) + 1'b1)));

  assert_cc_code_R7: assert property (@(posedge clk) disable iff (rst)
    cc != 2'b11);

  assert_return_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECODE && op == OP_RSUB) |=> (pc == $past(link)));

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (dev_rd && !dev_ready) |=> (dev_rd && $stable(dev_code)));

  assert_rd_upper_R10: assert property (@(posedge clk) disable iff (rst)
    (dev_rd && dev_ready) |=> (acc[WORD_W-1:BYTE_W] == $past(acc[WORD_W-1:BYTE_W])));

  assert_dev_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(dev_rd && dev_wr));

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && !mem_rd && !mem_wr));
endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  localparam int MEMSZ = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld  = 1'b0;
  logic [14:0] mem_addr;
  logic        mem_rd, mem_wr, dev_rd, dev_wr, dev_ready, halt;
  logic [7:0]  mem_wdata, dev_code, dev_wdata, dev_rdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mm [MEMSZ];
  logic [7:0]  bm [MEMSZ];
  int          busy = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;
  logic [7:0]  wd_log [$];
  logic [43:0] eq [$];
  string       tq [$];

  always #10 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_code(dev_code),
    .dev_rd(dev_rd), .dev_wr(dev_wr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .dev_ready(dev_ready), .halt(halt)
  );

  // memory and device models
  always @(posedge clk) begin
    if (ld) begin
      for (int i = 0; i < MEMSZ; i++) bm[i] <= mm[i];
    end else begin
      if (mem_wr) bm[mem_addr[8:0]] <= mem_wdata;
      if (mem_rd) mem_rdata <= bm[mem_addr[8:0]];
    end
    if ((dev_rd || dev_wr) && !dev_ready) busy <= busy + 1;
    else busy <= 0;
    if (dev_wr && dev_ready) wd_log.push_back(dev_wdata);
  end

  assign dev_ready = dev_code[0] || (busy >= 2);
  assign dev_rdata = dev_code ^ 8'h5A;

  task automatic check(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_ins(int at, int op, int xf, int adr);
    mm[at]   = op[7:0];
    mm[at+1] = {xf[0], adr[14:8]};
    mm[at+2] = adr[7:0];
  endtask

  task automatic put_word(int at, int w);
    mm[at] = w[23:16]; mm[at+1] = w[15:8]; mm[at+2] = w[7:0];
  endtask

  function automatic int rdw(int ad);
    return {8'h00, mm[ad % MEMSZ], mm[(ad+1) % MEMSZ], mm[(ad+2) % MEMSZ]};
  endfunction

  task automatic push(bit rd, bit wr, int ad, int wd, bit drd, bit dwr, int code, int dwd, bit hl, string tag);
    eq.push_back({rd, wr, ad[14:0], wd[7:0], drd, dwr, code[7:0], dwd[7:0], hl});
    tq.push_back(tag);
  endtask

  // behavioural reference: predicts every bus cycle
  task automatic run_model();
    int pc = 0, a = 0, x = 0, lk = 0, cc = 0, guard = 0;
    bit halted = 0, first = 1;
    while (!halted && guard < 400) begin
      int w, op, ta, v, code;
      string ft;
      guard++;
      ft = first ? "R1 reset fetch" : "R3 fetch";
      first = 0;
      for (int k = 0; k < 3; k++) push(1, 0, (pc + k) % 32768, 0, 0, 0, 0, 0, 0, ft);
      push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R3 fetch idle");
      w  = rdw(pc);
      op = (w >> 16) & 255;
      pc = (pc + 3) % 32768;
      ta = ((w >> 15) & 1) ? ((w & 32767) + x) % 32768 : (w & 32767);
      case (op)
        'h30, 'h34, 'h38, 'h3C: begin
          push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 jump decode");
          if (op == 'h3C || (op == 'h30 && cc == 0) || (op == 'h38 && cc == 1) || (op == 'h34 && cc == 2))
            pc = ta;
        end
        'h48: begin push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 call"); lk = pc; pc = ta; end
        'h4C: begin push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 return"); pc = lk; end
        'h0C, 'h10: begin
          int sv = (op == 'h0C) ? a : x;
          push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 decode");
          for (int k = 0; k < 3; k++) begin
            int b = (sv >> (16 - 8*k)) & 255;
            push(0, 1, (ta + k) % 32768, b, 0, 0, 0, 0, 0, "R5 store");
            mm[(ta + k) % MEMSZ] = b[7:0];
          end
        end
        'h00, 'h04, 'h18, 'h1C, 'h28, 'hE0, 'hD8, 'hDC: begin
          push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 decode");
          for (int k = 0; k < 3; k++) push(1, 0, (ta + k) % 32768, 0, 0, 0, 0, 0, 0, "R4 operand address");
          push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 operand idle");
          v = rdw(ta);
          code = (op >= 'hD8) ? ((v >> 16) & 255) : 0;
          push(0, 0, 0, 0, 0, 0, code, 0, 0, "R9 execute");
          case (op)
            'h00: a = v;
            'h04: x = v;
            'h18: a = (a + v) & 'hFFFFFF;
            'h1C: a = (a - v) & 'hFFFFFF;
            'h28: begin
              int sa = (a >= 'h800000) ? a - 'h1000000 : a;
              int sb = (v >= 'h800000) ? v - 'h1000000 : v;
              cc = (sa < sb) ? 1 : (sa == sb) ? 0 : 2;
            end
            'hE0: cc = (code & 1) ? 1 : 0;
            'hD8: begin
              int n = (code & 1) ? 1 : 3;
              for (int k = 0; k < n; k++) push(0, 0, 0, 0, 1, 0, code, 0, 0, "R10 device read");
              a = (a & 'hFFFF00) | (code ^ 'h5A);
            end
            default: begin
              int n = (code & 1) ? 1 : 3;
              for (int k = 0; k < n; k++) push(0, 0, 0, 0, 0, 1, code, a & 255, 0, "R11 device write");
            end
          endcase
        end
        default: begin
          push(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 decode");
          for (int k = 0; k < 8; k++) push(0, 0, 0, 0, 0, 0, 0, 0, 1, "R12 halt");
          halted = 1;
        end
      endcase
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) mm[i] = 8'h00;
    put_word('h100, 'h123456); put_word('h103, 'hF00001); put_word('h106, 3);
    put_word('h109, 'h000010); put_word('h10C, 'h7FFFFF);
    put_word('h10F, 'h050000); put_word('h112, 'h080000);
    put_ins(0, 'h00, 0, 'h100);   put_ins(3, 'h18, 0, 'h103);   put_ins(6, 'h0C, 0, 'h130);
    put_ins(9, 'h04, 0, 'h106);   put_ins(12, 'h00, 1, 'h109);  put_ins(15, 'h1C, 1, 'h100);
    put_ins(18, 'h0C, 0, 'h133);  put_ins(21, 'h28, 0, 'h100);  put_ins(24, 'h38, 0, 30);
    put_ins(27, 'hFF, 0, 0);      put_ins(30, 'h30, 0, 27);     put_ins(33, 'h34, 0, 27);
    put_ins(36, 'h00, 0, 'h100);  put_ins(39, 'h28, 0, 'h100);  put_ins(42, 'h30, 0, 48);
    put_ins(45, 'hFF, 0, 0);      put_ins(48, 'h28, 0, 'h103);  put_ins(51, 'h34, 0, 57);
    put_ins(54, 'hFF, 0, 0);      put_ins(57, 'h48, 0, 90);     put_ins(60, 'h10, 0, 'h136);
    put_ins(63, 'hE0, 0, 'h10F);  put_ins(66, 'h38, 0, 72);     put_ins(69, 'hFF, 0, 0);
    put_ins(72, 'hE0, 0, 'h112);  put_ins(75, 'h30, 0, 81);     put_ins(78, 'hFF, 0, 0);
    put_ins(81, 'h3C, 0, 96);     put_ins(90, 'hD8, 0, 'h10F);  put_ins(93, 'h4C, 0, 0);
    put_ins(96, 'hD8, 0, 'h112);  put_ins(99, 'hDC, 0, 'h10F);  put_ins(102, 'hDC, 0, 'h112);
    put_ins(105, 'h0C, 0, 'h139); put_ins(108, 'h0C, 1, 'h13C); put_ins(111, 'hFF, 0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk); ld = 1'b1;
    @(negedge clk); ld = 1'b0;
    run_model();
    @(negedge clk); rst = 1'b0;
    while (eq.size() > 0) begin
      logic [43:0] e, act;
      string t;
      e = eq.pop_front();
      t = tq.pop_front();
      act = {mem_rd, mem_wr, (mem_rd | mem_wr) ? mem_addr : 15'd0, mem_wr ? mem_wdata : 8'd0,
             dev_rd, dev_wr, dev_code, dev_wr ? dev_wdata : 8'd0, halt};
      check(act == e, t, {4'd0, act}, {4'd0, e});
      @(negedge clk);
    end
    check({bm['h130], bm['h131], bm['h132]} == 24'h023457, "R6 add truncates",
          {24'd0, bm['h130], bm['h131], bm['h132]}, 48'h023457);
    check({bm['h133], bm['h134], bm['h135]} == 24'h8FFFFE, "R6 subtract wraps",
          {24'd0, bm['h133], bm['h134], bm['h135]}, 48'h8FFFFE);
    check({bm['h136], bm['h137], bm['h138]} == 24'h000003, "R5 index store",
          {24'd0, bm['h136], bm['h137], bm['h138]}, 48'h000003);
    check({bm['h139], bm['h13A], bm['h13B]} == 24'h123452, "R10 low byte replaced",
          {24'd0, bm['h139], bm['h13A], bm['h13B]}, 48'h123452);
    check({bm['h13F], bm['h140], bm['h141]} == 24'h123452, "R4 indexed store target",
          {24'd0, bm['h13F], bm['h140], bm['h141]}, 48'h123452);
    check(wd_log.size() == 2, "R11 write count", 48'(wd_log.size()), 48'd2);
    if (wd_log.size() == 2)
      check(wd_log[0] == 8'h52 && wd_log[1] == 8'h52, "R11 written bytes",
            {32'd0, wd_log[0], wd_log[1]}, 48'h5252);
    for (int i = 'h130; i < 'h142; i++)
      check(bm[i] == mm[i], "R5 memory image", 48'(bm[i]), 48'(mm[i]));
    check(halt == 1'b1, "R12 halt held", 48'(halt), 48'd1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule